// File: doc/BRIEF.md
# Preset-Based Multi-Mode Up/Down Counter

This block holds a position count that moves one step per count pulse from an upstream phase decoder. A separate preset register works as a load value and as the boundary for three of the four count modes. In free mode the count wraps at the register width. In clamp mode it stops at zero and at the preset. In one-shot mode it halts after its first wrap, and in modulo mode it cycles between zero and the preset. Sticky carry, borrow and sign flags record wraps. The carry and borrow flags combine into a 25th count bit.

An index input can also load the preset into the count. In level mode a low index loads on every cycle it stays low. In aligned mode, which needs quadrature operation, the load happens only on a count pulse, and a polarity bit chooses the active level. A count-enable input gates all counting. A direction bit reports the last accepted pulse.

All inputs are assumed to be synchronous to `clk`. Every output is a register, or a function of registers only. There is no streamed data path, so every pin is a plain control or status signal.

Top module: `modal_count_core`

## Requirements
- R1: After reset the count, the preset and the carry, borrow, sign and error flags are all 0, and `dir_up` is 1.
- R2: With `mode`=0 (free), an accepted up pulse adds 1 and an accepted down pulse subtracts 1, wrapping at the register width. An up step from all-ones sets carry and clears sign. A down step from zero sets borrow and sets sign. `ext_count[24]` equals carry XOR borrow, and `ext_count[23:0]` equals the count.
- R3: With `mode`=1 (clamp), an up pulse has no effect while the count is at or above the preset, and a down pulse has no effect at zero. A pulse in the opposite direction moves the count again.
- R4: With `mode`=2 (one-shot), a step that wraps past all-ones or past zero still wraps and sets its flag. Later pulses then leave the count unchanged until a preset load, either from `load_now` or from the index.
- R5: With `mode`=3 (modulo), an up pulse at or above the preset gives 0 and sets carry. A down pulse at zero gives the preset and sets borrow. Any other pulse moves the count by 1.
- R6: While `cnt_en`=0, count pulses change neither the count nor `dir_up`.
- R7: Up and down pulses in the same enabled cycle cancel: the count holds and the error flag sets. `flag_clr` clears carry, borrow, sign and error on the next edge, and it wins over a set in the same cycle.
- R8: `load_now` copies the preset into the count on the next edge, and it wins over a count pulse in the same cycle. `preset_wr` updates the preset on the next edge, so a load in the same cycle uses the old preset.
- R9: With `idx_load_en`=1, and with either `idx_sync`=0 or `quad_mode`=0, the preset is loaded on every cycle in which `idx_in` is 0.
- R10: With `idx_load_en`=1, `idx_sync`=1 and `quad_mode`=1, the preset is loaded only in a cycle where `idx_in` equals `idx_pol` and a single enabled count pulse arrives. That pulse is not counted. Without a pulse, an active index has no effect.
- R11: `dir_up` becomes 1 after a lone enabled up pulse and 0 after a lone enabled down pulse. A cancelled pair leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable; 0 ignores all pulses |
| up | input | 1 | Count-up pulse, one cycle per step |
| dn | input | 1 | Count-down pulse, one cycle per step |
| quad_mode | input | 1 | 1 = pulses come from quadrature decoding; allows aligned index |
| mode | input | 2 | 0 free, 1 clamp, 2 one-shot, 3 modulo |
| preset_wr | input | 1 | Write `preset_data` into the preset |
| preset_data | input | 24 | New preset value |
| load_now | input | 1 | Copy the preset into the count |
| flag_clr | input | 1 | Clear carry, borrow, sign and error |
| idx_in | input | 1 | Index signal |
| idx_load_en | input | 1 | Enable preset load from the index |
| idx_sync | input | 1 | 1 = index aligned to count pulses |
| idx_pol | input | 1 | Active level of the index in aligned mode |
| count | output | 24 | Current count |
| preset | output | 24 | Current preset |
| ext_count | output | 25 | Count extended by carry XOR borrow |
| carry | output | 1 | Sticky overflow flag |
| borrow | output | 1 | Sticky underflow flag |
| sign | output | 1 | Set by underflow, cleared by overflow |
| error | output | 1 | Sticky flag for simultaneous up/down pulses |
| dir_up | output | 1 | Direction of the last accepted pulse, 1 = up |

## Verification
Each result is due on the first rising edge after the cycle that holds its stimulus. This covers a count step, a load, an index load, a flag change and a direction change. No result takes longer, because the index qualification and the step selection are combinational in front of a single register stage. The bench changes inputs on a falling edge and holds them for one full cycle. It reads the outputs at the next falling edge, which is half a period after the edge that must have updated them. Tests for "no effect" read the count and direction directly after the ignored cycle.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_CLAMP   = 2'd1,
    MODE_ONESHOT = 2'd2,
    MODE_MODN    = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic wrap_hi;
    logic wrap_lo;
  } wrap_evt_t;
endpackage

// File: rtl/mcc_index_qual.sv
module mcc_index_qual (
  input  logic idx_in,
  input  logic idx_pol,
  input  logic idx_sync,
  input  logic quad_mode,
  input  logic idx_load_en,
  input  logic qclk,
  output logic idx_load
);
  logic aligned;
  logic active;

  // aligned operation is only honoured when pulses come from quadrature decoding
  assign aligned  = idx_sync & quad_mode;
  assign active   = aligned ? (idx_in == idx_pol) : ~idx_in;
  assign idx_load = idx_load_en & active & (aligned ? qclk : 1'b1);
endmodule

// File: rtl/mcc_step.sv
module mcc_step
  import mcc_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] bound,
  input  cnt_mode_e    mode,
  input  logic         go_up,
  input  logic         go_dn,
  output logic [W-1:0] nxt,
  output wrap_evt_t    evt
);
  logic at_max, at_zero, at_top;

  assign at_max  = &cur;
  assign at_zero = (cur == '0);
  assign at_top  = (cur >= bound);

  always_comb begin
    nxt = cur;
    evt = '0;
    case (mode)
      MODE_CLAMP: begin
        if (go_up && !at_top)       nxt = cur + 1'b1;
        else if (go_dn && !at_zero) nxt = cur - 1'b1;
      end
      MODE_MODN: begin
        if (go_up) begin
          if (at_top) begin
            nxt = '0;
            evt.wrap_hi = 1'b1;
          end else begin
            nxt = cur + 1'b1;
          end
        end else if (go_dn) begin
          if (at_zero) begin
            nxt = bound;
            evt.wrap_lo = 1'b1;
          end else begin
            nxt = cur - 1'b1;
          end
        end
      end
      default: begin  // free and one-shot share the wrapping step
        if (go_up) begin
          nxt = cur + 1'b1;
          evt.wrap_hi = at_max;
        end else if (go_dn) begin
          nxt = cur - 1'b1;
          evt.wrap_lo = at_zero;
        end
      end
    endcase
  end
endmodule

// File: rtl/mcc_flags.sv
module mcc_flags
  import mcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flag_clr,
  input  wrap_evt_t evt,
  input  logic      collide,
  input  logic      step_up,
  input  logic      step_dn,
  output logic      carry,
  output logic      borrow,
  output logic      sign,
  output logic      error,
  output logic      dir_up
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry  <= 1'b0;
      borrow <= 1'b0;
      sign   <= 1'b0;
      error  <= 1'b0;
    end else if (flag_clr) begin
      carry  <= 1'b0;
      borrow <= 1'b0;
      sign   <= 1'b0;
      error  <= 1'b0;
    end else begin
      if (evt.wrap_hi) begin
        carry <= 1'b1;
        sign  <= 1'b0;
      end
      if (evt.wrap_lo) begin
        borrow <= 1'b1;
        sign   <= 1'b1;
      end
      if (collide) error <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir_up <= 1'b1;
    else if (step_up) dir_up <= 1'b1;
    else if (step_dn) dir_up <= 1'b0;
  end
endmodule

// File: rtl/modal_count_core.sv
module modal_count_core
  import mcc_pkg::*;
#(
  parameter int W = 24,
  localparam int XW = W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          up,
  input  logic          dn,
  input  logic          quad_mode,
  input  logic [1:0]    mode,
  input  logic          preset_wr,
  input  logic [W-1:0]  preset_data,
  input  logic          load_now,
  input  logic          flag_clr,
  input  logic          idx_in,
  input  logic          idx_load_en,
  input  logic          idx_sync,
  input  logic          idx_pol,
  output logic [W-1:0]  count,
  output logic [W-1:0]  preset,
  output logic [XW-1:0] ext_count,
  output logic          carry,
  output logic          borrow,
  output logic          sign,
  output logic          error,
  output logic          dir_up
);
  cnt_mode_e    mode_e;
  logic [W-1:0] count_q, preset_q, step_nxt;
  logic         halted_q;
  logic         one_up, one_dn, qclk, collide;
  logic         idx_load, do_load, stopped;
  wrap_evt_t    evt;

  assign mode_e  = cnt_mode_e'(mode);
  assign one_up  = cnt_en & up & ~dn;
  assign one_dn  = cnt_en & dn & ~up;
  assign qclk    = one_up | one_dn;
  assign collide = cnt_en & up & dn;

  mcc_index_qual u_idx (
    .idx_in      (idx_in),
    .idx_pol     (idx_pol),
    .idx_sync    (idx_sync),
    .quad_mode   (quad_mode),
    .idx_load_en (idx_load_en),
    .qclk        (qclk),
    .idx_load    (idx_load)
  );

  assign do_load = load_now | idx_load;
  assign stopped = halted_q & (mode_e == MODE_ONESHOT);

  mcc_step #(.W(W)) u_step (
    .cur   (count_q),
    .bound (preset_q),
    .mode  (mode_e),
    .go_up (one_up & ~do_load & ~stopped),
    .go_dn (one_dn & ~do_load & ~stopped),
    .nxt   (step_nxt),
    .evt   (evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      preset_q <= '0;
      halted_q <= 1'b0;
    end else begin
      count_q <= do_load ? preset_q : step_nxt;
      if (preset_wr) preset_q <= preset_data;
      if (do_load)
        halted_q <= 1'b0;
      else if (mode_e == MODE_ONESHOT && (evt.wrap_hi || evt.wrap_lo))
        halted_q <= 1'b1;
    end
  end

  mcc_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_clr (flag_clr),
    .evt      (evt),
    .collide  (collide),
    .step_up  (one_up),
    .step_dn  (one_dn),
    .carry    (carry),
    .borrow   (borrow),
    .sign     (sign),
    .error    (error),
    .dir_up   (dir_up)
  );

  assign count     = count_q;
  assign preset    = preset_q;
  assign ext_count = {carry ^ borrow, count_q};
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         up,
  input logic         dn,
  input logic         quad_mode,
  input logic [1:0]   mode,
  input logic         load_now,
  input logic         flag_clr,
  input logic         idx_load_en,
  input logic         idx_sync,
  input logic [W-1:0] count,
  input logic [W-1:0] preset,
  input logic         carry,
  input logic         error,
  input logic         dir_up
);
  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> count == $past(preset)); // R8

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load_now && !idx_load_en) |=> $stable(count)); // R6

  AST_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && up && dn && !load_now && !idx_load_en && !flag_clr)
      |=> ($stable(count) && error)); // R7

  AST_CLAMP_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && up && !dn && !load_now && !idx_load_en && count >= preset)
      |=> $stable(count)); // R3

  AST_MODN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && cnt_en && up && !dn && !load_now && !idx_load_en
     && !flag_clr && count >= preset) |=> (count == '0 && carry)); // R5

  AST_DIR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && up && !dn) |=> dir_up); // R11

  AST_ALIGNED_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_mode && idx_sync && !load_now && !(cnt_en && (up ^ dn)))
      |=> $stable(count)); // R10
endmodule

bind modal_count_core mcc_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_en      (cnt_en),
  .up          (up),
  .dn          (dn),
  .quad_mode   (quad_mode),
  .mode        (mode),
  .load_now    (load_now),
  .flag_clr    (flag_clr),
  .idx_load_en (idx_load_en),
  .idx_sync    (idx_sync),
  .count       (count),
  .preset      (preset),
  .carry       (carry),
  .error       (error),
  .dir_up      (dir_up)
);

// File: tb/tb_modal_count_core.sv
module tb_modal_count_core;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic cnt_en, up, dn, quad_mode, preset_wr, load_now, flag_clr;
  logic idx_in, idx_load_en, idx_sync, idx_pol;
  logic [1:0]   mode;
  logic [W-1:0] preset_data, count, preset;
  logic [W:0]   ext_count;
  logic carry, borrow, sign, error, dir_up;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  modal_count_core #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .up(up), .dn(dn),
    .quad_mode(quad_mode), .mode(mode), .preset_wr(preset_wr),
    .preset_data(preset_data), .load_now(load_now), .flag_clr(flag_clr),
    .idx_in(idx_in), .idx_load_en(idx_load_en), .idx_sync(idx_sync),
    .idx_pol(idx_pol), .count(count), .preset(preset), .ext_count(ext_count),
    .carry(carry), .borrow(borrow), .sign(sign), .error(error), .dir_up(dir_up)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic u, input logic d);
    up = u; dn = d;
    tick();
    up = 1'b0; dn = 1'b0;
  endtask

  task automatic write_preset(input logic [W-1:0] v);
    preset_wr = 1'b1; preset_data = v;
    tick();
    preset_wr = 1'b0;
  endtask

  task automatic do_load();
    load_now = 1'b1;
    tick();
    load_now = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "count", count, 0);
    chk("R1", "preset", preset, 0);
    chk("R1", "flags", {carry, borrow, sign, error}, 0);
    chk("R1", "dir_up", dir_up, 1);
  endtask

  task automatic t_free();
    mode = 2'd0;
    for (int i = 0; i < 3; i++) pulse(1, 0);
    chk("R2", "count up", count, 3);
    for (int i = 0; i < 5; i++) pulse(0, 1);
    chk("R2", "count wrap down", count, 24'hFFFFFE);
    chk("R2", "borrow/sign", {borrow, sign}, 2'b11);
    chk("R2", "ext_count", ext_count, 25'h1FFFFFE);
    clear_flags();
    write_preset(24'hFFFFFF);
    do_load();
    pulse(1, 0);
    chk("R2", "count wrap up", count, 0);
    chk("R2", "carry/sign", {carry, sign}, 2'b10);
    chk("R2", "ext_count top", ext_count, 25'h1000000);
    clear_flags();
  endtask

  task automatic t_clamp();
    mode = 2'd1;
    write_preset(0); do_load();
    write_preset(3);
    for (int i = 0; i < 5; i++) pulse(1, 0);
    chk("R3", "ceiling", count, 3);
    pulse(0, 1);
    chk("R3", "resume down", count, 2);
    for (int i = 0; i < 4; i++) pulse(0, 1);
    chk("R3", "floor", count, 0);
    chk("R3", "no borrow", borrow, 0);
  endtask

  task automatic t_oneshot();
    mode = 2'd2;
    clear_flags();
    write_preset(24'hFFFFFE); do_load();
    pulse(1, 0);
    chk("R4", "before wrap", count, 24'hFFFFFF);
    pulse(1, 0);
    chk("R4", "wrapped", count, 0);
    chk("R4", "carry", carry, 1);
    for (int i = 0; i < 3; i++) pulse(1, 0);
    chk("R4", "halted", count, 0);
    do_load();
    pulse(1, 0);
    chk("R4", "re-enabled by load", count, 24'hFFFFFF);
    clear_flags();
    write_preset(0); do_load();
    pulse(0, 1);
    chk("R4", "under wrap", count, 24'hFFFFFF);
    chk("R4", "borrow", borrow, 1);
    pulse(0, 1);
    chk("R4", "halted low", count, 24'hFFFFFF);
  endtask

  task automatic t_modn();
    mode = 2'd3;
    clear_flags();
    write_preset(0); do_load();
    write_preset(2);
    pulse(1, 0); pulse(1, 0);
    chk("R5", "reach preset", count, 2);
    pulse(1, 0);
    chk("R5", "wrap to zero", count, 0);
    chk("R5", "carry", carry, 1);
    pulse(0, 1);
    chk("R5", "wrap to preset", count, 2);
    chk("R5", "borrow", borrow, 1);
    pulse(0, 1);
    chk("R5", "step down", count, 1);
  endtask

  task automatic t_enable();
    mode = 2'd0;
    write_preset(24'h00000A); do_load();
    cnt_en = 1'b0;
    for (int i = 0; i < 3; i++) pulse(1, 0);
    chk("R6", "count held", count, 24'h0A);
    chk("R6", "dir held", dir_up, 0);
    cnt_en = 1'b1;
  endtask

  task automatic t_collide();
    clear_flags();
    pulse(1, 1);
    chk("R7", "count held", count, 24'h0A);
    chk("R7", "error", error, 1);
    chk("R11", "dir unchanged", dir_up, 0);
    clear_flags();
    chk("R7", "cleared", {carry, borrow, sign, error}, 0);
  endtask

  task automatic t_load();
    preset_wr = 1'b1; preset_data = 24'h123456; load_now = 1'b1;
    tick();
    preset_wr = 1'b0; load_now = 1'b0;
    chk("R8", "old preset used", count, 24'h0A);
    chk("R8", "preset written", preset, 24'h123456);
    load_now = 1'b1;
    pulse(1, 0);
    load_now = 1'b0;
    chk("R8", "load beats pulse", count, 24'h123456);
  endtask

  task automatic t_idx_level();
    write_preset(24'h40);
    idx_load_en = 1'b1; idx_sync = 1'b0; quad_mode = 1'b1;
    idx_in = 1'b0; tick(); idx_in = 1'b1;
    chk("R9", "index load", count, 24'h40);
    pulse(1, 0);
    chk("R9", "inactive index", count, 24'h41);
    pulse(1, 0);
    quad_mode = 1'b0; idx_sync = 1'b1; idx_pol = 1'b1;
    idx_in = 1'b0; tick(); idx_in = 1'b1;
    chk("R9", "aligned refused w/o quad", count, 24'h40);
  endtask

  task automatic t_idx_aligned();
    quad_mode = 1'b1; idx_sync = 1'b1; idx_pol = 1'b1; idx_in = 1'b0;
    pulse(1, 0);
    chk("R10", "inactive level counts", count, 24'h41);
    idx_in = 1'b1; tick();
    chk("R10", "no pulse no load", count, 24'h41);
    pulse(1, 0);
    chk("R10", "load on pulse", count, 24'h40);
    idx_pol = 1'b0; idx_in = 1'b1;
    pulse(1, 0);
    chk("R10", "pol0 inactive", count, 24'h41);
    idx_in = 1'b0;
    pulse(1, 0);
    chk("R10", "pol0 load", count, 24'h40);
    idx_load_en = 1'b0; idx_sync = 1'b0; idx_in = 1'b1;
  endtask

  task automatic t_dir();
    pulse(1, 0);
    chk("R11", "dir after up", dir_up, 1);
    pulse(0, 1);
    chk("R11", "dir after down", dir_up, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b1; up = 1'b0; dn = 1'b0; quad_mode = 1'b0;
    mode = 2'd0; preset_wr = 1'b0; preset_data = '0; load_now = 1'b0;
    flag_clr = 1'b0; idx_in = 1'b1; idx_load_en = 1'b0; idx_sync = 1'b0;
    idx_pol = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_free();
    t_clamp();
    t_oneshot();
    t_modn();
    t_enable();
    t_collide();
    t_load();
    t_idx_level();
    t_idx_aligned();
    t_dir();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule